// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple clocked request port and an external asynchronous static RAM of 512K words by 16 bits. A requester offers one access at a time: a 19-bit word address, a 16-bit write word and a write flag. The controller then runs the RAM's control pins through a fixed sequence. Each step of that sequence lasts a number of clock cycles set by a parameter, so the RAM's nanosecond minimums hold at the chosen clock period.

The RAM is selected only while its active-low enable is low and its active-high enable is high. Every access runs through the same steps:

- one setup cycle, in which address and selects are driven and both strobes are high;
- a counted strobe phase, with the write strobe low for a write or the read strobe low for a read;
- one hold cycle, in which the strobe is released while the address and select are kept;
- after a read only, a counted bus-release phase before the controller may drive the data bus again.

A read word is captured on the last cycle of its strobe phase. A one-cycle done pulse presents it to the requester.

With the defaults at a 5 ns clock, the timing works out as follows. The write strobe stays low for 13 cycles, which gives 65 ns of pulse width and 70 ns from a valid address to the end of the write. The read strobe stays low for 14 cycles, so the address is stable for 75 ns before capture. After a read, 4 release cycles keep the data bus free for well over 30 ns after the RAM's output is switched off.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, ram_en_n is 1, ram_en is 0, ram_wr_n is 1, ram_rd_n is 1, the data bus is not driven, req_ready is 1 and rsp_done is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 until the access sequence has finished.
- R3: The RAM is selected (ram_en_n 0, ram_en 1) exactly in cycles 1 to N+2 after acceptance. N is WR_PULSE_CYC for a write and RD_ACCESS_CYC for a read. ram_addr equals the request address throughout that window, and a strobe is only ever low while the RAM is selected.
- R4: For a write, ram_wr_n is low in cycles 2 to N+1 after acceptance and high otherwise. ram_rd_n stays high for the whole write.
- R5: For a write, the controller drives the request word on ram_data from cycle 2 to cycle N+2. Both ram_addr and the driven word stay constant while ram_wr_n is low.
- R6: For a read, ram_rd_n is low in cycles 2 to N+1 after acceptance, ram_wr_n stays high, and the controller never drives ram_data while ram_rd_n is low.
- R7: The word on ram_data in the last cycle with ram_rd_n low is returned on rsp_rdata.
- R8: rsp_done is high for exactly one cycle, in cycle N+2 after acceptance, and both strobes are high in that cycle. rsp_rdata changes only on reads; after a write it still holds the previous read word.
- R9: After a write, req_ready returns in cycle N+3. After a read, it returns in cycle N+3+TURN_CYC (TURN_CYC at least 1), and the RAM stays deselected during the release cycles.
- R10: With the default parameters at a 5 ns clock, each write meets these minimums: a low pulse of at least 35 ns, at least 70 ns from a valid address to the end of the write, and at least 30 ns of data setup before that end. Each read sees at least 70 ns from address and select, and at least 35 ns from the read strobe. Write data is never driven within 30 ns after the RAM's output is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Word address of the request |
| req_wdata | input | 16 | Word to write |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last word read |
| ram_addr | output | 19 | RAM address |
| ram_data | inout | 16 | RAM bidirectional data bus |
| ram_en_n | output | 1 | RAM select, active low |
| ram_en | output | 1 | RAM select, active high |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_rd_n | output | 1 | RAM output enable, active low |

## Verification
A sequencer stuck in or skipping a state shows up immediately as a strobe edge in the wrong cycle relative to acceptance. The bench compares every cycle of every access against the expected pattern, so such an error is reported within one cycle of its first effect. A wrong strobe count or a missing release phase is caught on the same access: by the behavioural RAM as a short pulse, too little setup or early data drive, or by the bench as a shifted done pulse or ready edge. A capture on the wrong cycle or from the wrong register shows up as a mismatched rsp_rdata on that read's done pulse, or on the next read after a write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Access sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TURN   = 3'd4
  } sram_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Count down to zero after a load, then rest
  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_io.sv
module sram_bus_io #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic              op_write,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  // Request fields, loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      op_write <= req_write;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  // Read word, loaded on the last strobe cycle of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WR_PULSE_CYC  = 13,
  parameter int RD_ACCESS_CYC = 14,
  parameter int TURN_CYC      = 4,
  parameter int CNT_W         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             op_write,
  input  logic             cnt_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             sel_act,
  output logic             wr_act,
  output logic             rd_act,
  output logic             drv_act,
  output logic             capture,
  output logic             done_q
);

  sram_state_e state_q;
  sram_state_e state_d;
  logic        last_access;

  // Next-state and counter load
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d  = ST_ACCESS;
        cnt_load = 1'b1;
        cnt_val  = op_write ? CNT_W'(WR_PULSE_CYC - 1) : CNT_W'(RD_ACCESS_CYC - 1);
      end
      ST_ACCESS: begin
        if (cnt_zero) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (op_write) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_TURN;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_TURN: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign last_access = (state_q == ST_ACCESS) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= last_access;
    end
  end

  // Pin-level activity decoded from the registered phase
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign sel_act   = (state_q == ST_SETUP) || (state_q == ST_ACCESS) || (state_q == ST_HOLD);
  assign wr_act    = (state_q == ST_ACCESS) && op_write;
  assign rd_act    = (state_q == ST_ACCESS) && !op_write;
  assign drv_act   = ((state_q == ST_ACCESS) || (state_q == ST_HOLD)) && op_write;
  assign capture   = last_access && !op_write;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8

  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int WR_PULSE_CYC  = 13,
  parameter int RD_ACCESS_CYC = 14,
  parameter int TURN_CYC      = 4   // must be 1 or more
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [DATA_W-1:0] ram_data,
  output logic              ram_en_n,
  output logic              ram_en,
  output logic              ram_wr_n,
  output logic              ram_rd_n
);

  localparam int CNT_MAX = max3(WR_PULSE_CYC, RD_ACCESS_CYC, TURN_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic             accept;
  logic             op_write;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             sel_act;
  logic             wr_act;
  logic             rd_act;
  logic             dq_oe;
  logic             capture;
  logic [DATA_W-1:0] dq_out;

  sram_seq_fsm #(
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .RD_ACCESS_CYC(RD_ACCESS_CYC),
    .TURN_CYC     (TURN_CYC),
    .CNT_W        (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(req_valid),
    .op_write (op_write),
    .cnt_zero (cnt_zero),
    .req_ready(req_ready),
    .accept   (accept),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .sel_act  (sel_act),
    .wr_act   (wr_act),
    .rd_act   (rd_act),
    .drv_act  (dq_oe),
    .capture  (capture),
    .done_q   (rsp_done)
  );

  sram_wait_cnt #(
    .CNT_W(CNT_W)
  ) wait_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .zero    (cnt_zero)
  );

  sram_bus_io #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) io_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .accept   (accept),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .capture  (capture),
    .bus_in   (ram_data),
    .op_write (op_write),
    .addr_q   (ram_addr),
    .wdata_q  (dq_out),
    .rdata_q  (rsp_rdata)
  );

  // Pin drive
  assign ram_en_n = !sel_act;
  assign ram_en   = sel_act;
  assign ram_wr_n = !wr_act;
  assign ram_rd_n = !rd_act;
  assign ram_data = dq_oe ? dq_out : {DATA_W{1'bz}};

  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ram_wr_n || !ram_rd_n) |-> (!ram_en_n && ram_en)); // R3

  AST_ADDR_HELD_WR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ram_wr_n |=> $stable(ram_addr)); // R5

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dq_oe |=> (!dq_oe || $stable(dq_out))); // R5

  AST_NO_DRIVE_RD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ram_rd_n |-> !dq_oe); // R6

  AST_STROBES_OFF_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_done |-> (ram_rd_n && ram_wr_n)); // R8

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (ram_en_n && !ram_en && !dq_oe)); // R9

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

  localparam int WR   = 13;
  localparam int RD   = 14;
  localparam int TURN = 4;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [18:0] ram_addr;
  wire  [15:0] ram_data;
  logic        ram_en_n;
  logic        ram_en;
  logic        ram_wr_n;
  logic        ram_rd_n;

  sram_async_ctrl #(
    .WR_PULSE_CYC (WR),
    .RD_ACCESS_CYC(RD),
    .TURN_CYC     (TURN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_data(ram_data), .ram_en_n(ram_en_n), .ram_en(ram_en),
    .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk;
  int n_bad;
  bit finished;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM ----------------
  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  logic        ram_drv;
  logic [15:0] ram_out;
  real t_addr, t_rd, t_sel, t_on, t_wstart, t_dchg;
  bit  win_q;
  wire sel = !ram_en_n && ram_en;

  assign ram_data = ram_drv ? ram_out : 16'hzzzz;

  function automatic logic [15:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(ram_addr) begin
    t_addr = $realtime;
    if (sel && !ram_wr_n) chk(1'b0, "R5 address moved while write strobe low", 32'(ram_addr), 0);
  end
  always @(ram_data) t_dchg = $realtime;
  always @(negedge ram_rd_n) t_rd = $realtime;
  always @(negedge ram_en_n) t_sel = $realtime;

  always @(ram_wr_n or ram_en_n or ram_en) begin
    bit w;
    w = !ram_en_n && ram_en && !ram_wr_n;
    if (w && !win_q) begin
      t_wstart = $realtime;
      chk(!ram_drv, "R10 write drive while RAM output still on", 32'(ram_drv), 0);
    end else if (!w && win_q) begin
      chk(($realtime - t_wstart) >= 35.0, "R10 write pulse width ns", 32'(int'($realtime - t_wstart)), 35);
      chk(($realtime - t_addr) >= 70.0, "R10 address to end of write ns", 32'(int'($realtime - t_addr)), 70);
      chk(($realtime - t_dchg) >= 30.0, "R10 data setup ns", 32'(int'($realtime - t_dchg)), 30);
      mem[int'(ram_addr)] = ram_data;
    end
    win_q = w;
  end

  // Output driver: poisoned until access times are met, stays on 30 ns after disable
  initial begin
    ram_drv = 1'b0;
    ram_out = 16'h0000;
    win_q   = 1'b0;
    t_addr = -1000.0; t_rd = -1000.0; t_sel = -1000.0; t_on = -1000.0;
    t_wstart = -1000.0; t_dchg = -1000.0;
    forever begin
      #1;
      if (sel && ram_wr_n && !ram_rd_n) begin
        ram_drv = 1'b1;
        t_on    = $realtime;
        if (($realtime - t_addr >= 70.0) && ($realtime - t_rd >= 35.0) && ($realtime - t_sel >= 70.0))
          ram_out = mem_rd(int'(ram_addr));
        else
          ram_out = ~mem_rd(int'(ram_addr));
      end else if (ram_drv && ($realtime - t_on >= 30.0)) begin
        ram_drv = 1'b0;
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] last_rd;

  task automatic run_op(input bit wr, input logic [18:0] a, input logic [15:0] d);
    int n;
    n = wr ? WR : RD;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    for (int k = 1; k <= n + 2; k++) begin
      bit strobe;
      strobe = (k >= 2) && (k <= n + 1);
      chk(!ram_en_n && ram_en, "R3 select active", {ram_en_n, ram_en}, 32'b01);
      chk(ram_addr == a, "R3 address held", 32'(ram_addr), 32'(a));
      chk(!req_ready, "R2 ready low while busy", 32'(req_ready), 0);
      if (wr) begin
        chk(ram_wr_n == !strobe, "R4 write strobe", 32'(ram_wr_n), 32'(!strobe));
        chk(ram_rd_n, "R4 read strobe high in write", 32'(ram_rd_n), 1);
        if (k >= 2) chk(ram_data === d, "R5 write data on bus", 32'(ram_data), 32'(d));
      end else begin
        chk(ram_rd_n == !strobe, "R6 read strobe", 32'(ram_rd_n), 32'(!strobe));
        chk(ram_wr_n, "R6 write strobe high in read", 32'(ram_wr_n), 1);
      end
      chk(rsp_done == (k == n + 2), "R8 done timing", 32'(rsp_done), 32'(k == n + 2));
      if (k == n + 2) begin
        if (wr) begin
          chk(rsp_rdata == last_rd, "R8 rdata unchanged by write", 32'(rsp_rdata), 32'(last_rd));
        end else begin
          chk(rsp_rdata == exp_rd(int'(a)), "R7 read word", 32'(rsp_rdata), 32'(exp_rd(int'(a))));
          last_rd = exp_rd(int'(a));
        end
      end
      @(negedge clk);
    end
    if (wr) shadow[int'(a)] = d;
    // now in cycle n+3
    chk(!rsp_done, "R8 done is one cycle", 32'(rsp_done), 0);
    if (!wr) begin
      for (int t = 0; t < TURN; t++) begin
        chk(!req_ready, "R9 ready held during release", 32'(req_ready), 0);
        chk(ram_en_n && !ram_en, "R9 deselected during release", {ram_en_n, ram_en}, 32'b10);
        @(negedge clk);
      end
    end
    chk(req_ready, "R9 ready returns", 32'(req_ready), 1);
  endtask

  logic [18:0] pool [8];

  initial begin
    void'($urandom(32'h5EED_0001));
    n_chk = 0; n_bad = 0; finished = 1'b0;
    last_rd = 16'h0000;
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001; pool[3] = 19'h40000;
    pool[4] = 19'h2AAAA; pool[5] = 19'h55555; pool[6] = 19'h12345; pool[7] = 19'h7FFFE;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    chk(ram_en_n && !ram_en, "R1 deselected in reset", {ram_en_n, ram_en}, 32'b10);
    chk(ram_wr_n && ram_rd_n, "R1 strobes high in reset", {ram_wr_n, ram_rd_n}, 32'b11);
    chk(!rsp_done, "R1 no done in reset", 32'(rsp_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);
    chk(ram_en_n && !ram_en && ram_wr_n && ram_rd_n, "R1 quiet after reset",
        {ram_en_n, ram_en, ram_wr_n, ram_rd_n}, 32'b1011);

    // directed corners
    run_op(1'b0, 19'h12345, 16'h0);       // unwritten location
    run_op(1'b1, 19'h00000, 16'hFFFF);
    run_op(1'b1, 19'h7FFFF, 16'h0000);
    run_op(1'b0, 19'h00000, 16'h0);
    run_op(1'b0, 19'h7FFFF, 16'h0);
    run_op(1'b1, 19'h55555, 16'hA5A5);    // read followed by write: release window
    run_op(1'b0, 19'h55555, 16'h0);
    run_op(1'b1, 19'h55555, 16'h5A5A);    // write straight after read
    run_op(1'b1, 19'h2AAAA, 16'h1234);    // write after write
    run_op(1'b0, 19'h55555, 16'h0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit          w;
      logic [18:0] a;
      w = 1'($urandom % 2);
      a = ($urandom % 3 == 0) ? 19'($urandom) : pool[$urandom % 8];
      run_op(w, a, 16'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule